// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small register file on a peripheral bus clock and its timing logic on a separate oscillator clock. Software programs a 12-bit timeout value, sets an enable bit, and must then service the watchdog regularly. Time is counted in units of 2^PRESCALE_LOG2 oscillator cycles, so one timeout spans (value + 1) such units.

When the first timeout expires without service, the block raises an interrupt. If a second full timeout then runs out with no service, it drives a reset pulse of fixed length, stops counting and clears the interrupt. Software must enable it again after that. Software services the watchdog by writing 1 to bit 0 of the service register. This clears the interrupt and restarts the time count.

Configuration writes (enable, timeout value, count clear) cross into the oscillator domain through a toggle handshake. A busy bit shows while one is in flight, and configuration writes made while busy are dropped. Service writes never wait and never set busy.

Top module: `wdt_timer`

## Requirements
- R1: After reset, irq_o and wdt_rst_o are 0, and reads of the control register (offset 0x0) and the service register (offset 0xC) return 0.
- R2: In the timeout register (offset 0x4), only bits [31:20] are stored, as the 12-bit timeout value N. Bits [19:0] are ignored on write and read back as 0.
- R3: Bit 0 of the control register enables counting. Reading that bit returns the enable state as seen in the oscillator domain. Bit 1 reads 1 while a configuration write is crossing domains. With counting disabled, no interrupt is raised.
- R4: A write to the control, timeout or elapsed register (offset 0x8) made while bit 1 of the control register reads 1 is dropped.
- R5: After enable, with a cleared count, irq_o rises (N+1)*2^PRESCALE_LOG2 oscillator cycles after the enable takes effect, plus at most 8 cycles of crossing latency.
- R6: If there is no service after irq_o rises, wdt_rst_o rises exactly (N+1)*2^PRESCALE_LOG2 oscillator cycles later and stays high for RST_CYCLES oscillator cycles.
- R7: When the reset pulse fires, irq_o clears and counting stops. Bit 0 of the control register then reads 0, and no further interrupt occurs until the block is enabled again.
- R8: Writing 1 to bit 0 of the service register clears irq_o within 8 oscillator cycles and restarts the time count. Writing 0 there has no effect.
- R9: Any write to the elapsed register zeroes the time count. Reads of that register return 0.
- R10: Bit 0 of the service register reads the interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| osc_clk_i | input | 1 | Oscillator clock for the timing logic |
| bus_sel_i | input | 1 | Bus access strobe (one cycle per write) |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt after the first timeout without service |
| wdt_rst_o | output | 1 | Reset pulse after the second timeout without service |

## Verification
The hardest state to reach is the second timeout. The bench has to let one full timeout expire, keep the interrupt pending, and show that a zero write to the service register changes nothing. It then lets the second timeout run out while the bench measures, in oscillator cycles, the gap from interrupt to reset and the width of the pulse. The dropped-write case needs a second configuration write to land inside the handshake window. The bench issues it on the pclk cycle right after a control write, while the busy bit is still set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PERIOD_W   = 12;
  localparam int PERIOD_LSB = 20;
  localparam int ADDR_W     = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_ELAPSED = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_SVC     = 4'hC;

  typedef struct packed {
    logic                en;
    logic                en_wr;
    logic [PERIOD_W-1:0] period;
    logic                clr;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int PING_HOLD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output wdt_cfg_t          cfg_o,
  output logic              req_tgl_o,
  input  logic              ack_tgl_i,
  output logic              ping_o,
  input  logic              run_i,
  input  logic              irq_i
);
  localparam int HOLD_W = $clog2(PING_HOLD + 1);

  wdt_cfg_t          cfg_q;
  logic              req_q;
  logic [HOLD_W-1:0] hold_q;
  logic              busy, wr, wr_cfg, wr_ping;
  logic              unused_wdata;

  assign busy    = req_q ^ ack_tgl_i;
  assign wr      = bus_sel_i & bus_we_i;
  assign wr_cfg  = wr & ~busy & (bus_addr_i == ADDR_CTRL || bus_addr_i == ADDR_PERIOD ||
                                 bus_addr_i == ADDR_ELAPSED);
  assign wr_ping = wr & (bus_addr_i == ADDR_SVC) & bus_wdata_i[0];
  assign unused_wdata = ^bus_wdata_i[PERIOD_LSB-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      req_q <= 1'b0;
    end else if (wr_cfg) begin
      req_q       <= ~req_q;
      cfg_q.en_wr <= 1'b0;
      cfg_q.clr   <= 1'b0;
      case (bus_addr_i)
        ADDR_CTRL: begin
          cfg_q.en    <= bus_wdata_i[0];
          cfg_q.en_wr <= 1'b1;
        end
        ADDR_PERIOD: cfg_q.period <= bus_wdata_i[31:PERIOD_LSB];
        default:     cfg_q.clr    <= 1'b1;
      endcase
    end
  end

  // service is a stretched level so that the slower domain cannot miss it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hold_q <= '0;
    else if (wr_ping)        hold_q <= HOLD_W'(PING_HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign ping_o    = (hold_q != '0);
  assign cfg_o     = cfg_q;
  assign req_tgl_o = req_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_CTRL:   bus_rdata_o[1:0] = {busy, run_i};
      ADDR_PERIOD: bus_rdata_o[31:PERIOD_LSB] = cfg_q.period;
      ADDR_SVC:    bus_rdata_o[0] = irq_i;
      default:     bus_rdata_o = '0;
    endcase
  end

  p_busy_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && busy) |=> ($stable(cfg_q) && $stable(req_q)));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 20,
  parameter int RST_CYCLES    = 4
) (
  input  logic     osc_clk_i,
  input  logic     rst_ni,
  input  wdt_cfg_t cfg_i,
  input  logic     req_s_i,
  input  logic     ping_s_i,
  output logic     ack_tgl_o,
  output logic     run_o,
  output logic     irq_o,
  output logic     wdt_rst_o
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [PRESCALE_LOG2-1:0] pre_q;
  logic [PERIOD_W-1:0]      per_q, period_q;
  logic [RST_W-1:0]         rst_cnt_q;
  logic                     req_d, ping_d, run_q, irq_q;
  logic                     req_evt, ping_evt, expire;

  assign req_evt  = req_s_i ^ req_d;
  assign ping_evt = ping_s_i & ~ping_d;
  assign expire   = run_q && (&pre_q) && (per_q >= period_q);

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d     <= 1'b0;
      ping_d    <= 1'b0;
      pre_q     <= '0;
      per_q     <= '0;
      period_q  <= '0;
      run_q     <= 1'b0;
      irq_q     <= 1'b0;
      rst_cnt_q <= '0;
    end else begin
      req_d  <= req_s_i;
      ping_d <= ping_s_i;
      if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (expire) begin
        pre_q <= '0;
        per_q <= '0;
        if (irq_q) begin
          irq_q     <= 1'b0;
          run_q     <= 1'b0;
          rst_cnt_q <= RST_W'(RST_CYCLES);
        end else begin
          irq_q <= 1'b1;
        end
      end else if (run_q) begin
        if (&pre_q) per_q <= per_q + 1'b1;
        pre_q <= pre_q + 1'b1;
      end
      // cfg_i is held stable by the bus side until the ack returns
      if (req_evt) begin
        period_q <= cfg_i.period;
        if (cfg_i.en_wr) run_q <= cfg_i.en;
        if (cfg_i.clr) begin
          pre_q <= '0;
          per_q <= '0;
        end
      end
      if (ping_evt) begin
        irq_q <= 1'b0;
        pre_q <= '0;
        per_q <= '0;
      end
    end
  end

  assign ack_tgl_o = req_d;
  assign run_o     = run_q;
  assign irq_o     = irq_q;
  assign wdt_rst_o = (rst_cnt_q != '0);

  p_rst_needs_irq_r6: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(irq_q));
  p_halt_on_rst_r7: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (wdt_rst_o && !req_evt) |-> !run_q);
  p_ping_clears_r8: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ping_evt |=> !irq_q);
  p_irq_needs_run_r5: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(run_q));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 20,
  parameter int RST_CYCLES    = 4,
  parameter int PING_HOLD     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_clk_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  wdt_cfg_t cfg;
  logic     req_tgl, ping, ack_tgl, run, irq;
  logic     req_s, ping_s, ack_s, run_s, irq_s;

  wdt_regs #(.PING_HOLD(PING_HOLD)) u_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .cfg_o(cfg), .req_tgl_o(req_tgl), .ack_tgl_i(ack_s), .ping_o(ping),
    .run_i(run_s), .irq_i(irq_s)
  );

  wdt_sync #(.WIDTH(2)) u_to_osc (
    .clk_i(osc_clk_i), .rst_ni, .d_i({req_tgl, ping}), .q_o({req_s, ping_s})
  );

  wdt_sync #(.WIDTH(3)) u_to_bus (
    .clk_i, .rst_ni, .d_i({ack_tgl, run, irq}), .q_o({ack_s, run_s, irq_s})
  );

  wdt_core #(.PRESCALE_LOG2(PRESCALE_LOG2), .RST_CYCLES(RST_CYCLES)) u_core (
    .osc_clk_i, .rst_ni, .cfg_i(cfg), .req_s_i(req_s), .ping_s_i(ping_s),
    .ack_tgl_o(ack_tgl), .run_o(run), .irq_o(irq), .wdt_rst_o
  );

  assign irq_o = irq;
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  localparam int P    = 4;
  localparam int RSTC = 4;
  localparam int N    = 2;
  localparam int M    = (N + 1) << P;

  logic        clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, wrst;

  int checks = 0, fails = 0;
  int oc = 0, irq_rise_t = 0, irq_rises = 0, rst_rise_t = 0, rst_rises = 0;
  int rst_w = 0, last_w = 0, both_hi = 0;
  logic irq_p = 1'b0, rst_p = 1'b0;

  always #2 clk = ~clk;
  always #5 osc = ~osc;

  wdt_timer #(.PRESCALE_LOG2(P), .RST_CYCLES(RSTC), .PING_HOLD(8)) u_wdt_timer (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  // behavioural event model on the oscillator clock
  always @(negedge osc) begin
    oc++;
    if (irq && !irq_p) begin irq_rise_t = oc; irq_rises++; end
    if (wrst && !rst_p) begin rst_rise_t = oc; rst_rises++; rst_w = 0; end
    if (wrst) rst_w++;
    if (!wrst && rst_p) last_w = rst_w;
    if (irq && wrst) both_hi++;
    irq_p = irq;
    rst_p = wrst;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      rd(4'h0, v);
      if (!v[1]) break;
    end
  endtask

  task automatic osc_wait(input int n);
    repeat (n) @(negedge osc);
  endtask

  task automatic wait_irq(input int prev);
    for (int i = 0; i < 2000 && irq_rises == prev; i++) @(negedge osc);
  endtask

  initial begin
    logic [31:0] v;
    int t0, n0, r0;
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0, n0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(irq == 1'b0 && wrst == 1'b0, "R1 outputs", {irq, wrst}, 0);
    rd(4'h0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(4'hC, v); chk(v == 0, "R1 svc", v, 0);
    // R2
    wr(4'h4, 32'hFFFF_FFFF); wait_idle();
    rd(4'h4, v); chk(v == 32'hFFF0_0000, "R2 mask all ones", v, 32'hFFF0_0000);
    wr(4'h4, 32'h0020_0ABC); wait_idle();
    rd(4'h4, v); chk(v == 32'h0020_0000, "R2 N=2", v, 32'h0020_0000);
    // R3 busy, R4 dropped write
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk(v[1] == 1'b1, "R3 busy", v[1], 1);
    wr(4'h4, 32'h0050_0000);
    wait_idle();
    rd(4'h4, v); chk(v == 32'h0020_0000, "R4 dropped", v, 32'h0020_0000);
    // R9 read returns zero
    rd(4'h8, v); chk(v == 0, "R9 read", v, 0);
    // R3 disabled: no interrupt
    osc_wait(100);
    chk(irq_rises == 0, "R3 disabled", irq_rises, 0);
    // R5 first timeout
    n0 = irq_rises; t0 = oc;
    wr(4'h0, 32'h1);
    wait_idle();
    rd(4'h0, v); chk(v[0] == 1'b1, "R3 enable readback", v[0], 1);
    wait_irq(n0);
    chk(irq_rise_t - t0 >= M && irq_rise_t - t0 <= M + 8, "R5 delay", irq_rise_t - t0, M);
    rd(4'hC, v); chk(v == 1, "R10 irq read", v, 1);
    wr(4'hC, 32'h0);
    osc_wait(5);
    rd(4'hC, v); chk(irq == 1'b1 && v == 1, "R8 zero write ignored", v, 1);
    // R6 second timeout
    for (int i = 0; i < 2000 && rst_rises == 0; i++) @(negedge osc);
    chk(rst_rise_t - irq_rise_t == M, "R6 gap", rst_rise_t - irq_rise_t, M);
    osc_wait(RSTC + 2);
    chk(last_w == RSTC, "R6 width", last_w, RSTC);
    // R7
    repeat (4) @(negedge clk);
    rd(4'h0, v); chk(v[0] == 1'b0, "R7 disabled", v[0], 0);
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    n0 = irq_rises;
    osc_wait(3 * M);
    chk(irq_rises == n0 && rst_rises == 1, "R7 halted", irq_rises - n0, 0);
    // R8 ping
    n0 = irq_rises;
    wr(4'h0, 32'h1); wait_idle();
    wait_irq(n0);
    r0 = rst_rises; n0 = irq_rises; t0 = oc;
    wr(4'hC, 32'h1);
    osc_wait(8);
    chk(irq == 1'b0, "R8 ping clears", irq, 0);
    wait_irq(n0);
    chk(irq_rise_t - t0 >= M && irq_rise_t - t0 <= M + 8, "R8 restart", irq_rise_t - t0, M);
    chk(rst_rises == r0, "R8 no reset", rst_rises, r0);
    wr(4'h0, 32'h0); wait_idle();
    wr(4'hC, 32'h1); osc_wait(10);
    // R9 clear elapsed count
    wr(4'h0, 32'h1); wait_idle();
    osc_wait(30);
    wr(4'h0, 32'h0); wait_idle();
    wr(4'h8, 32'h0); wait_idle();
    n0 = irq_rises; t0 = oc;
    wr(4'h0, 32'h1);
    wait_irq(n0);
    chk(irq_rise_t - t0 >= M && irq_rise_t - t0 <= M + 8, "R9 cleared", irq_rise_t - t0, M);
    wr(4'h0, 32'h0); wait_idle();
    chk(both_hi == 0, "R7 irq and reset never together", both_hi, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule